// File: doc/BRIEF.md
# Synchronizable Three-Phase Switching Clock Generator

This block produces cycle-start pulses for three converter channels. It runs from a fast system clock. Normally the block follows a free-running oscillator tick that arrives once per programmed switching period. It can also follow an asynchronous external sync input that runs at three times the switching rate. Dividing that sync stream by three gives three natural 120-degree slots, one for each channel.

The block measures the oscillator period in system clocks. It uses that measurement for three things: to spread the channels in oscillator mode, to decide whether a sync edge train is fast enough to be trusted, and to declare that sync has been lost. A phase-mode input selects either staggered phasing, where the channels start one third of a cycle apart, or aligned phasing, where all three start together. A per-channel spacing guard keeps the transitions between sources clean. The guard stops any channel from being restarted too soon after its previous start.

Top module: `phase_clock_gen`

## Requirements
- R1: `sync_in` passes through a two-flop synchronizer. Only its low-to-high transitions count as sync events, and one transition is one event, however long the input stays high.
- R2: When locked with `align_mode`=0, successive sync events start channel 1, channel 2 and channel 3 in rotation. Channel 1 is `ch_start[0]`, channel 2 is `ch_start[1]` and channel 3 is `ch_start[2]`. The first event after lock goes to channel 1, so consecutive pulses are one sync period apart and each channel runs at one third of the sync rate.
- R3: When locked with `align_mode`=1, the first sync event after lock, and every third event after it, drives `ch_start`=3'b111. The events in between produce no pulse.
- R4: The oscillator period T is the number of system clocks between two successive `osc_tick` pulses, and it is known once two ticks have been seen. With T known, `sync_locked` rises after two consecutive sync intervals that are each at most floor(5*T/18) clocks, which is the interval of a sync rate 1.2 times three times the oscillator rate.
- R5: A sync train whose intervals exceed floor(5*T/18) never sets `sync_locked`, and it leaves the oscillator-driven pulses unchanged.
- R6: When locked, if no sync event arrives for T clocks, `sync_locked` clears and the channels again follow `osc_tick`.
- R7: When unlocked with `align_mode`=0, channel 1 pulses one clock after each `osc_tick`. Channel 2 pulses floor(T/3) clocks after channel 1, and channel 3 pulses 2*floor(T/3) clocks after channel 1.
- R8: When unlocked with `align_mode`=1, each `osc_tick` produces `ch_start`=3'b111 one clock later.
- R9: No channel is ever started twice within floor(T/3) clocks, including across changes between sync and oscillator control.
- R10: During and straight after reset, `ch_start` is 0 and `sync_locked` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-clock pulse per internal switching period |
| sync_in | input | 1 | Asynchronous external sync, three times the switching rate |
| align_mode | input | 1 | 0: channels staggered by 120 degrees, 1: channels aligned |
| ch_start | output | 3 | Registered cycle-start pulses; bit 0 is channel 1 |
| sync_locked | output | 1 | High while the channels follow the external sync |

## Verification
A wrong rotation index or slot count appears at once as a pulse on the wrong bit of `ch_start`, or as a spacing that differs from one sync period or one third of T. The scoreboard catches it on the next pulse. A wrong lock window, or a timeout that fires late or never, shows on `sync_locked` within a few sync periods. When the lock is false, a slow train also reorders or breaks the oscillator-driven sequence. A guard that does not hold back a restart shows as two pulses on one channel closer than floor(T/3). That can only appear at a change of source, so the bench checks the spacing on every pulse it sees.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  // Staggering slot: one third of the measured oscillator period.
  function automatic int unsigned slot_len(input int unsigned period);
    return period / 3;
  endfunction

  // Longest sync interval that still counts as valid:
  // sync rate >= 1.2 * 3 * internal rate  ->  interval <= T / 3.6 = 5T/18.
  function automatic int unsigned sync_gap_max(input int unsigned period);
    return (period * 5) / 18;
  endfunction

endpackage

// File: rtl/pcg_edge_sync.sv
module pcg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  // R1: one transition yields a single-cycle event
  assert_rise_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pcg_period_meter.sv
module pcg_period_meter #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [PER_W-1:0] period_o,
  output logic             valid_o
);
  logic [PER_W-1:0] cnt_q;
  logic [1:0]       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_o <= '0;
      seen_q   <= '0;
    end else if (tick_i) begin
      period_o <= cnt_q;
      cnt_q    <= PER_W'(1);
      if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign valid_o = (seen_q == 2'd2);

  // R7: the measured period only changes on a tick
  assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(period_o));
endmodule

// File: rtl/pcg_lock_track.sv
module pcg_lock_track #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             period_valid_i,
  output logic             locked_o
);
  logic [PER_W-1:0] gap_q;
  logic             seen_q;
  logic [1:0]       good_q;
  logic [PER_W-1:0] gap_max;
  logic             gap_ok;
  logic             timeout;

  assign gap_max = PER_W'(pcg_pkg::sync_gap_max(32'(period_i)));
  assign gap_ok  = seen_q && (gap_q <= gap_max);
  assign timeout = seen_q && (gap_q >= period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      good_q <= 2'd0;
    end else if (!period_valid_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      good_q <= 2'd0;
    end else if (rise_i) begin
      gap_q  <= PER_W'(1);
      seen_q <= 1'b1;
      if (!gap_ok)             good_q <= 2'd0;
      else if (good_q != 2'd2) good_q <= good_q + 2'd1;
    end else begin
      if (gap_q != '1) gap_q <= gap_q + PER_W'(1);
      if (timeout) begin
        seen_q <= 1'b0;
        good_q <= 2'd0;
      end
    end
  end

  assign locked_o = (good_q == 2'd2);

  // R4: lock only exists on top of a measured oscillator period
  assert_lock_needs_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> period_valid_i);
  // R6: a silent sync input drops the lock on the next cycle
  assert_loss_on_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !rise_i && timeout) |=> !locked_o);
endmodule

// File: rtl/pcg_pulse_guard.sv
module pcg_pulse_guard #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [PER_W-1:0] slot_i,
  output logic             fire_o
);
  logic [PER_W-1:0] since_q;

  assign fire_o = req_i && (since_q >= slot_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= '1;
    else if (fire_o)           since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + PER_W'(1);
  end

  // R9: a granted start is never followed by another on the next cycle
  assert_guard_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && slot_i > PER_W'(1)) |=> !fire_o);
endmodule

// File: rtl/phase_clock_gen.sv
module phase_clock_gen #(
  parameter int PER_W    = 16,
  parameter int N_CH     = 3,
  parameter int SYNC_STG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic            sync_in,
  input  logic            align_mode,
  output logic [N_CH-1:0] ch_start,
  output logic            sync_locked
);
  localparam int IDX_W = $clog2(N_CH);

  logic             sync_rise;
  logic [PER_W-1:0] period;
  logic             period_valid;
  logic [PER_W-1:0] slot;
  logic [PER_W:0]   slot2;
  logic [IDX_W-1:0] idx_q;
  logic [PER_W-1:0] st_cnt_q;
  logic             st_run_q;
  logic [N_CH-1:0]  req;
  logic [N_CH-1:0]  fire;

  pcg_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sync_in), .rise_o(sync_rise));

  pcg_period_meter #(.PER_W(PER_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .tick_i(osc_tick),
    .period_o(period), .valid_o(period_valid));

  pcg_lock_track #(.PER_W(PER_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .rise_i(sync_rise), .period_i(period),
    .period_valid_i(period_valid), .locked_o(sync_locked));

  assign slot  = PER_W'(pcg_pkg::slot_len(32'(period)));
  assign slot2 = {slot, 1'b0};

  // rotation index over sync events while locked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (!sync_locked)     idx_q <= '0;
    else if (sync_rise)        idx_q <= (idx_q == IDX_W'(N_CH-1)) ? '0 : idx_q + IDX_W'(1);
  end

  // stagger counter for oscillator mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_run_q <= 1'b0;
      st_cnt_q <= '0;
    end else if (sync_locked || align_mode) begin
      st_run_q <= 1'b0;
    end else if (osc_tick && period_valid) begin
      st_run_q <= 1'b1;
      st_cnt_q <= PER_W'(1);
    end else if (st_run_q) begin
      if ({1'b0, st_cnt_q} >= slot2) st_run_q <= 1'b0;
      else                           st_cnt_q <= st_cnt_q + PER_W'(1);
    end
  end

  always_comb begin
    req = '0;
    if (sync_locked) begin
      if (sync_rise) begin
        if (align_mode) begin
          if (idx_q == '0) req = '1;
        end else begin
          req[idx_q] = 1'b1;
        end
      end
    end else begin
      if (osc_tick) begin
        if (align_mode) req = '1;
        else            req[0] = 1'b1;
      end
      if (st_run_q && !align_mode) begin
        for (int c = 1; c < N_CH; c++) begin
          if (PER_W'(32'(slot) * c) == st_cnt_q) req[c] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_guard
    pcg_pulse_guard #(.PER_W(PER_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .req_i(req[g]), .slot_i(slot), .fire_o(fire[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_start <= '0;
    else        ch_start <= fire;
  end

  // R2: staggered phasing never starts two channels in one cycle
  assert_stagger_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!align_mode && !$past(align_mode)) |-> $onehot0(ch_start));
endmodule

// File: tb/tb_phase_clock_gen.sv
module tb_phase_clock_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       sync_in = 1'b0;
  logic       align_mode = 1'b0;
  logic [2:0] ch_start;
  logic       sync_locked;

  localparam int T_OSC = 900;
  localparam int SLOT  = T_OSC / 3;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int sync_per = 0;
  logic [2:0] exp_q[$];
  bit    armed = 0;
  int    last_t = 0;
  int    exp_gap = 0;
  string cur_tag = "R7";
  int    last_ch[3] = '{-1000000, -1000000, -1000000};
  bit    watch_unlock = 0;
  int    unlock_bad = 0;

  phase_clock_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sync_in(sync_in),
    .align_mode(align_mode), .ch_start(ch_start), .sync_locked(sync_locked));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint got, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    end
  endtask

  // oscillator: one-cycle tick every T_OSC clocks
  initial begin
    forever begin
      repeat (T_OSC - 1) @(negedge clk);
      osc_tick = 1'b1;
      @(negedge clk);
      osc_tick = 1'b0;
    end
  end

  // external sync driver
  initial begin
    forever begin
      if (sync_per == 0) begin
        sync_in = 1'b0;
        @(negedge clk);
      end else begin
        sync_in = 1'b1;
        repeat (sync_per / 2) @(negedge clk);
        sync_in = 1'b0;
        repeat (sync_per - sync_per / 2) @(negedge clk);
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (watch_unlock && sync_locked) unlock_bad++;
      if (ch_start != 3'b000) begin
        for (int i = 0; i < 3; i++) begin
          if (ch_start[i]) begin
            chk(cyc - last_ch[i] >= SLOT, "R9", "same-channel spacing", cyc - last_ch[i], SLOT);
            last_ch[i] = cyc;
          end
        end
        if (armed) begin
          if (exp_q.size() == 0) begin
            chk(0, cur_tag, "unexpected pulse mask", ch_start, 0);
          end else begin
            logic [2:0] e;
            e = exp_q.pop_front();
            chk(ch_start == e, cur_tag, "pulse mask", ch_start, e);
            chk(cyc - last_t == exp_gap, cur_tag, "pulse spacing", cyc - last_t, exp_gap);
          end
          last_t = cyc;
        end
      end
    end
  end

  task automatic arm_after(logic [2:0] m, int gap, string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (ch_start != m && n < 5000);
    chk(ch_start == m, tag, "trigger pulse", ch_start, m);
    last_t = cyc;
    exp_gap = gap;
    cur_tag = tag;
    @(posedge clk);
    armed = 1;
  endtask

  task automatic push(logic [2:0] m);
    exp_q.push_back(m);
  endtask

  task automatic drain(string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 8000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, tag, "expected pulses left", exp_q.size(), 0);
    armed = 0;
    exp_q.delete();
  endtask

  task automatic wait_lock(bit level, int limit, string tag);
    int n = 0;
    while (sync_locked != level && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(sync_locked == level, tag, "sync_locked level", sync_locked, level);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    // R10: reset state
    repeat (4) @(negedge clk);
    chk(ch_start == 3'b000, "R10", "ch_start in reset", ch_start, 0);
    chk(sync_locked == 1'b0, "R10", "sync_locked in reset", sync_locked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ch_start == 3'b000, "R10", "ch_start after reset", ch_start, 0);
    chk(sync_locked == 1'b0, "R10", "sync_locked after reset", sync_locked, 0);

    // R7: oscillator mode, staggered
    repeat (2 * T_OSC + 10) @(negedge clk);
    arm_after(3'b001, SLOT, "R7");
    push(3'b010); push(3'b100); push(3'b001); push(3'b010); push(3'b100);
    drain("R7");

    // R5: slow sync train, never locks, internal sequence intact
    sync_per = 300;
    watch_unlock = 1;
    arm_after(3'b001, SLOT, "R5");
    for (int k = 0; k < 3; k++) begin
      push(3'b010); push(3'b100); push(3'b001);
    end
    drain("R5");
    watch_unlock = 0;
    chk(unlock_bad == 0, "R5", "cycles locked on slow sync", unlock_bad, 0);

    // R4 / R2 / R1: valid sync, staggered
    sync_per = 240;
    wait_lock(1'b1, 3000, "R4");
    arm_after(3'b001, 240, "R2");
    push(3'b010); push(3'b100); push(3'b001); push(3'b010); push(3'b100);
    drain("R2");

    // R6: sync loss, back to oscillator
    sync_per = 0;
    t0 = cyc;
    wait_lock(1'b0, 3000, "R6");
    chk(cyc - t0 <= T_OSC + 250, "R6", "cycles to drop lock", cyc - t0, T_OSC + 250);
    arm_after(3'b001, SLOT, "R6");
    push(3'b010); push(3'b100); push(3'b001);
    drain("R6");

    // R8: oscillator mode, aligned
    align_mode = 1'b1;
    arm_after(3'b111, T_OSC, "R8");
    push(3'b111); push(3'b111); push(3'b111);
    drain("R8");

    // R3 / R1: sync mode, aligned (every third rising edge)
    sync_per = 240;
    wait_lock(1'b1, 3000, "R4");
    arm_after(3'b111, 720, "R3");
    push(3'b111); push(3'b111); push(3'b111);
    drain("R3");
    chk(sync_locked == 1'b1, "R1", "lock held on steady sync", sync_locked, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule